// File: doc/BRIEF.md
# Minutes-and-Seconds Up/Down Timer

This block holds a four-digit MM:SS time value as packed BCD. A single-cycle tick enable, arriving once per second from a divider elsewhere in the clock domain, moves the value by one second. A direction input chooses whether the tick advances the value or retreats it. The two units digits are ordinary decade stages. The two tens digits run modulo 6, so the value never goes past 59:59, and wraps and borrows cross the minute boundary correctly.

Software or key logic outside the block can preset all four digits at once from a parallel bus using an active-low load strobe. An active-high clear zeroes the value. Any preset digit outside its legal range is clamped before it is stored. A tone-enable output is high whenever all sixteen stored bits are zero, so a buzzer driver can sound at 00:00. When counting down, the value rests at 00:00 instead of rolling over. When counting up, 59:59 rolls over to 00:00.

Top module: `mmss_updown_timer`

## Requirements
- R1: After reset is asserted (rst_n low), digits_out is 16'h0000 and tone is 1.
- R2: clr high at a rising edge sets every digit to 0 at that edge. This happens regardless of load_n, tick and count_up.
- R3: load_n low with clr low stores the preset bus at the edge. The bus fields are [3:0] seconds units, [7:4] seconds tens, [11:8] minutes units and [15:12] minutes tens. A load overrides a tick in the same cycle.
- R4: When loaded, a units field above 9 is stored as 9 and a tens field above 5 is stored as 5. Every stored units digit is at most 9, and every stored tens digit is at most 5.
- R5: When count_up is 1, a tick with no clear or load raises seconds units by one. A units digit of 9 becomes 0 and carries into the next digit.
- R6: When counting up, a tens digit at 5 that receives a carry becomes 0. A seconds-tens wrap carries into minutes units, so xx:59 becomes (xx+1):00 and 09:59 becomes 10:00.
- R7: When count_up is 0, a tick lowers the value by one second. A units digit at 0 becomes 9 and a tens digit at 0 becomes 5 when borrowed from, so 10:00 becomes 09:59.
- R8: When count_up is 0 and the value is 00:00, a tick leaves the value at 00:00.
- R9: When counting up, a tick at 59:59 gives 00:00.
- R10: With tick low and clr low and load_n high, the value does not change, whatever count_up is.
- R11: tone is 1 exactly when all sixteen bits of digits_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-second step enable, one cycle wide |
| count_up | input | 1 | 1 selects counting up, 0 selects counting down |
| clr | input | 1 | Synchronous active-high clear |
| load_n | input | 1 | Synchronous active-low preset strobe |
| preset_bcd | input | 16 | Preset digits: MM tens, MM units, SS tens, SS units, from high to low nibble |
| digits_out | output | 16 | Stored digits, same field layout as preset_bcd |
| tone | output | 1 | High while the value reads 00:00 |

## Verification
A tick can land in the same cycle as a load or a clear, and that collision is the main interaction tested. The bench drives tick together with load_n low, and with clr high and load_n low, at values where a count step would give a different result. It then checks that the new value is the clamped preset in the first case and 00:00 in the second, not the stepped value. A second collision is a down tick at 00:00, where the hold rule and the borrow chain meet. Here the bench checks that the value and the tone both stay put.

// File: rtl/mmss_pkg.sv
package mmss_pkg;
   localparam int unsigned BCD_W     = 4;
   localparam int unsigned UNITS_TOP = 9;
   localparam int unsigned TENS_TOP  = 5;

   typedef logic [BCD_W-1:0] bcd_t;

   // Even positions are units digits, odd positions are tens digits.
   function automatic int unsigned digit_top(input int unsigned pos);
      return (pos % 2 == 1) ? TENS_TOP : UNITS_TOP;
   endfunction
endpackage

// File: rtl/mmss_preset_clamp.sv
module mmss_preset_clamp #(
   parameter int unsigned W   = 4,
   parameter int unsigned TOP = 9
) (
   input  logic [W-1:0] raw,
   output logic [W-1:0] legal
);
   localparam logic [W-1:0] TOP_V = W'(TOP);

   always_comb begin
      legal = (raw > TOP_V) ? TOP_V : raw;
   end
endmodule

// File: rtl/mmss_digit_stage.sv
module mmss_digit_stage #(
   parameter int unsigned W   = 4,
   parameter int unsigned TOP = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   input  logic         up,
   output logic [W-1:0] q,
   output logic         at_edge
);
   localparam logic [W-1:0] TOP_V = W'(TOP);
   localparam logic [W-1:0] ONE_V = W'(1);

   logic [W-1:0] stepped;

   // The next stage steps only when this one sits at the edge it leaves from.
   always_comb begin
      at_edge = up ? (q == TOP_V) : (q == '0);
      if (up) stepped = (q == TOP_V) ? '0 : q + ONE_V;
      else    stepped = (q == '0) ? TOP_V : q - ONE_V;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (clr)   q <= '0;
      else if (load)  q <= load_val;
      else if (step)  q <= stepped;
   end
endmodule

// File: rtl/mmss_zero_detect.sv
module mmss_zero_detect #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] vec,
   output logic         all_zero
);
   always_comb all_zero = ~|vec;
endmodule

// File: rtl/mmss_updown_timer.sv
module mmss_updown_timer #(
   parameter int unsigned NUM_DIGITS = 4,
   parameter int unsigned DIGIT_W    = mmss_pkg::BCD_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          tick,
   input  logic                          count_up,
   input  logic                          clr,
   input  logic                          load_n,
   input  logic [NUM_DIGITS*DIGIT_W-1:0] preset_bcd,
   output logic [NUM_DIGITS*DIGIT_W-1:0] digits_out,
   output logic                          tone
);
   localparam int unsigned TOTAL_W = NUM_DIGITS * DIGIT_W;

   if (NUM_DIGITS < 2 || NUM_DIGITS % 2 != 0) begin : g_bad_digits
      $error("NUM_DIGITS must be an even number of at least 2");
   end
   if (DIGIT_W < 4) begin : g_bad_width
      $error("DIGIT_W must hold a decimal digit");
   end

   logic                  at_zero;
   logic                  load;
   logic [NUM_DIGITS-1:0] step;
   logic [NUM_DIGITS-1:0] edge_hit;

   assign load = ~load_n;

   // Down counting rests at the all-zero value.
   assign step[0] = tick & (count_up | ~at_zero);

   for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
      localparam int unsigned TOP = mmss_pkg::digit_top(g);
      logic [DIGIT_W-1:0] legal_val;

      if (g > 0) begin : g_chain
         assign step[g] = step[g-1] & edge_hit[g-1];
      end

      mmss_preset_clamp #(.W(DIGIT_W), .TOP(TOP)) u_clamp (
         .raw   (preset_bcd[g*DIGIT_W +: DIGIT_W]),
         .legal (legal_val)
      );

      mmss_digit_stage #(.W(DIGIT_W), .TOP(TOP)) u_stage (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (clr),
         .load     (load),
         .load_val (legal_val),
         .step     (step[g]),
         .up       (count_up),
         .q        (digits_out[g*DIGIT_W +: DIGIT_W]),
         .at_edge  (edge_hit[g])
      );
   end

   mmss_zero_detect #(.W(TOTAL_W)) u_zero (
      .vec      (digits_out),
      .all_zero (at_zero)
   );

   assign tone = at_zero;
endmodule

// File: rtl/mmss_timer_checker.sv
module mmss_timer_checker #(
   parameter int unsigned NUM_DIGITS = 4,
   parameter int unsigned DIGIT_W    = 4
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          tick,
   input logic                          count_up,
   input logic                          clr,
   input logic                          load_n,
   input logic [NUM_DIGITS*DIGIT_W-1:0] preset_bcd,
   input logic [NUM_DIGITS*DIGIT_W-1:0] digits_out,
   input logic                          tone
);
   function automatic logic preset_ok(input logic [NUM_DIGITS*DIGIT_W-1:0] v);
      logic ok;
      ok = 1'b1;
      for (int i = 0; i < NUM_DIGITS; i++) begin
         if (int'(v[i*DIGIT_W +: DIGIT_W]) > int'(mmss_pkg::digit_top(i))) ok = 1'b0;
      end
      return ok;
   endfunction

   p_tone_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      tone == (digits_out == '0));

   p_clear_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> digits_out == '0);

   p_load_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load_n && preset_ok(preset_bcd)) |=> digits_out == $past(preset_bcd));

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && load_n && !tick) |=> $stable(digits_out));

   p_down_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && load_n && tick && !count_up && digits_out == '0) |=> digits_out == '0);

   for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_rng
      p_digit_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
         int'(digits_out[g*DIGIT_W +: DIGIT_W]) <= int'(mmss_pkg::digit_top(g)));
   end
endmodule

bind mmss_updown_timer mmss_timer_checker #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) u_chk (.*);

// File: tb/tb_mmss_updown_timer.sv
`timescale 1ns/1ps
module tb_mmss_updown_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        count_up = 1'b1;
   logic        clr = 1'b0;
   logic        load_n = 1'b1;
   logic [15:0] preset_bcd = '0;
   logic [15:0] digits_out;
   logic        tone;

   int errors = 0;
   int checks = 0;
   int model_s = 0;
   bit done = 1'b0;

   typedef struct {
      logic [15:0] d;
      logic        t;
      string       tag;
   } exp_t;
   exp_t sb_q[$];

   always #10 clk = ~clk;

   mmss_updown_timer dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .count_up(count_up),
      .clr(clr), .load_n(load_n), .preset_bcd(preset_bcd),
      .digits_out(digits_out), .tone(tone)
   );

   function automatic logic [15:0] to_bcd(input int s);
      logic [15:0] r;
      r[15:12] = 4'(s / 600);
      r[11:8]  = 4'((s / 60) % 10);
      r[7:4]   = 4'((s % 60) / 10);
      r[3:0]   = 4'(s % 10);
      return r;
   endfunction

   function automatic int from_preset(input logic [15:0] p);
      int mt, mu, st, su;
      mt = (p[15:12] > 5) ? 5 : int'(p[15:12]);
      mu = (p[11:8]  > 9) ? 9 : int'(p[11:8]);
      st = (p[7:4]   > 5) ? 5 : int'(p[7:4]);
      su = (p[3:0]   > 9) ? 9 : int'(p[3:0]);
      return mt * 600 + mu * 60 + st * 10 + su;
   endfunction

   task automatic drive(input logic tk, input logic up, input logic cl,
                        input logic ldn, input logic [15:0] pv, input string tag);
      @(negedge clk);
      tick = tk; count_up = up; clr = cl; load_n = ldn; preset_bcd = pv;
      if (cl)             model_s = 0;
      else if (!ldn)      model_s = from_preset(pv);
      else if (tk && up)  model_s = (model_s + 1) % 3600;
      else if (tk && model_s != 0) model_s = model_s - 1;
      @(posedge clk);
      #1;
      sb_q.push_back('{d: to_bcd(model_s), t: (model_s == 0), tag: tag});
   endtask

   // Monitor: compares each expected item half a cycle after its edge.
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (digits_out !== e.d || tone !== e.t) begin
               errors++;
               $display("FAIL %s: digits=%h tone=%b expected digits=%h tone=%b",
                        e.tag, digits_out, tone, e.d, e.t);
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (digits_out !== 16'h0000 || tone !== 1'b1) begin
         errors++;
         $display("FAIL R1 reset: digits=%h tone=%b expected digits=0000 tone=1", digits_out, tone);
      end
      rst_n = 1'b1;

      drive(0, 1, 0, 0, 16'h1234, "R3 load 12:34");
      drive(1, 1, 0, 1, 16'h0000, "R5 up tick 12:35");
      for (int i = 0; i < 6; i++) drive(1, 1, 0, 1, 16'h0000, "R5 up units wrap");
      drive(0, 0, 0, 1, 16'h0000, "R10 idle down-select");
      drive(0, 1, 0, 1, 16'h0000, "R10 idle up-select");
      drive(0, 1, 0, 0, 16'h0059, "R3 load 00:59");
      drive(1, 1, 0, 1, 16'h0000, "R6 00:59 to 01:00");
      drive(0, 1, 0, 0, 16'h0959, "R3 load 09:59");
      drive(1, 1, 0, 1, 16'h0000, "R6 09:59 to 10:00");
      drive(0, 1, 0, 0, 16'h5959, "R3 load 59:59");
      drive(1, 1, 0, 1, 16'h0000, "R9 59:59 to 00:00");
      drive(1, 0, 0, 1, 16'h0000, "R8 down hold at 00:00");
      drive(1, 0, 0, 1, 16'h0000, "R8 down hold again");
      drive(0, 0, 0, 0, 16'h1000, "R3 load 10:00");
      drive(1, 0, 0, 1, 16'h0000, "R7 10:00 to 09:59");
      drive(0, 0, 0, 0, 16'h0001, "R3 load 00:01");
      drive(1, 0, 0, 1, 16'h0000, "R11 down to 00:00 tone");
      drive(0, 1, 0, 0, 16'hFFFF, "R4 clamp FFFF");
      drive(0, 1, 0, 0, 16'hA6A6, "R4 clamp A6A6");
      drive(0, 1, 0, 0, 16'h7C9B, "R4 clamp 7C9B");
      drive(1, 1, 0, 0, 16'h4321, "R3 load beats tick");
      drive(1, 0, 1, 0, 16'h3333, "R2 clear beats load and tick");
      drive(1, 1, 0, 1, 16'h0000, "R5 up from 00:00");
      drive(0, 0, 0, 0, 16'h0205, "R3 load 02:05");
      for (int i = 0; i < 130; i++) drive(1, 0, 0, 1, 16'h0000, "R7 long down run");
      for (int i = 0; i < 70; i++) drive(1, 1, 0, 1, 16'h0000, "R6 long up run");
      drive(0, 1, 1, 1, 16'h0000, "R2 clear alone");
      drive(0, 1, 0, 1, 16'h0000, "R10 idle");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule